// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block sits between a PWM request and the two gate-enable outputs of a synchronous buck power stage. One output drives the high-side switch and one drives the low-side switch. It keeps the two switches from ever conducting together. A fixed dead-time counter would be the usual approach, but this block waits on comparator flags instead. Each flag reports that a gate voltage has actually fallen below its turn-off threshold. Only after the opposite gate's flag is seen, and a constant delay has then elapsed, does the controller let the requested gate rise.

Two override inputs take precedence over the PWM request. A shutdown input, or a dropped enable, turns both gates off so the output floats. An over-voltage input turns the high side off and steers the stage to the low side for as long as it is held. The low side is still reached through the normal feedback wait. The constant delay is counted in clock cycles and is derived from three parameters: the clock period, the typical dead time and the maximum dead time.

The delay length, written DLY below, is ceil(DEAD_TIME_NS / CLK_PERIOD_NS). It is clamped to at least 1 and to at most floor(DEAD_MAX_NS / CLK_PERIOD_NS). With the defaults (10 ns, 40 ns, 100 ns), DLY is 4.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: While `rst` is high, and afterwards for as long as `enable` is low, both `hs_gate_en` and `ls_gate_en` are 0, whatever `pwm_req` does.
- R2: `hs_gate_en` and `ls_gate_en` are never 1 in the same cycle.
- R3: When the request is high, `hs_gate_en` rises at the (DLY+1)-th rising edge, counting the first edge that samples `ls_fb_low`=1 (while waiting for the high side) as edge 1. This holds only if `ls_fb_low` stays 1 on all those edges.
- R4: When the request is low, `ls_gate_en` rises at the (DLY+1)-th rising edge, counting the first edge that samples `hs_fb_low`=1 (while waiting for the low side) as edge 1. This holds only if `hs_fb_low` stays 1 on all those edges.
- R5: If the awaited feedback flag reads 0 on any edge during the delay, the delay is abandoned. The count restarts from edge 1 the next time the flag reads 1.
- R6: While the awaited feedback flag stays 0, the requested gate stays off with no time limit.
- R7: If the effective request changes while a wait or a delay is in progress, the pending turn-on is dropped at that edge. The controller then waits on the other gate's feedback flag.
- R8: When `shutdown` is 1 or `enable` is 0 at a rising edge, both enables are 0 after that edge. On release, the controller restarts through the feedback wait, and nothing turns on before the full wait and delay.
- R9: While `ovp_force` is 1, `hs_gate_en` is 0 from the next edge onward. The low side is reached through the R4 sequence and held.
- R10: A request held constant after its gate has turned on causes no further change on either enable.
- R11: With default parameters, DLY is 4 clock cycles (40 ns at 10 ns). A lit gate turns off at the first edge that samples the opposite effective request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; 0 holds both gates off |
| shutdown | input | 1 | 1 forces both gates off (output floats) |
| ovp_force | input | 1 | Over-voltage override; 1 steers to low side |
| pwm_req | input | 1 | PWM request; 1 = high side, 0 = low side |
| hs_fb_low | input | 1 | 1 = high-side gate-to-switch-node voltage below threshold |
| ls_fb_low | input | 1 | 1 = low-side gate voltage below threshold |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |

## Verification
A wrong internal phase shows at the ports within one clock. The outputs are decoded directly from the phase register, so a phase stuck in a delay or in an on state appears as a gate lit too early, too late or at the wrong side. The reference model predicts both enables on every cycle, and the turn-on latency is checked to the exact edge for each path: a first start, a side change, a glitch during the delay, a reversed request, shutdown release and over-voltage. A miscounted delay shows as a rise one or more edges off. A lost feedback qualification shows as a gate that rises while its opposite flag is withheld.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_HI_WAIT = 3'd1,
        PH_HI_DLY  = 3'd2,
        PH_HI_ON   = 3'd3,
        PH_LO_WAIT = 3'd4,
        PH_LO_DLY  = 3'd5,
        PH_LO_ON   = 3'd6
    } phase_e;

    typedef struct packed {
        logic run;      // controller allowed to drive a gate
        logic want_hi;  // effective side request: 1 = high side
    } req_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;

    // Delay in cycles: ceil(dead/clk), clamped to [1, floor(max/clk)]
    function automatic int calc_dly(input int dead_ns, input int max_ns, input int clk_ns);
        int c;
        int lim;
        c   = (dead_ns + clk_ns - 1) / clk_ns;
        lim = max_ns / clk_ns;
        if (c > lim) c = lim;
        if (c < 1)   c = 1;
        return c;
    endfunction

    function automatic logic is_delay(input phase_e p);
        return (p == PH_HI_DLY) || (p == PH_LO_DLY);
    endfunction

endpackage

// File: rtl/dtg_req_qual.sv
module dtg_req_qual
    import dtg_pkg::*;
(
    input  logic enable,
    input  logic shutdown,
    input  logic ovp_force,
    input  logic pwm_req,
    output req_t req
);
    always_comb begin
        req.run     = enable & ~shutdown;
        req.want_hi = pwm_req & ~ovp_force;
    end
endmodule

// File: rtl/dtg_delay_timer.sv
module dtg_delay_timer #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = active && (cnt_q == LAST);
endmodule

// File: rtl/dtg_phase_fsm.sv
module dtg_phase_fsm
    import dtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  req_t   req,
    input  logic   hi_fb_low,
    input  logic   lo_fb_low,
    input  logic   timer_done,
    output phase_e phase,
    output logic   timer_active
);
    phase_e ph_q;
    phase_e ph_d;

    always_comb begin
        ph_d = ph_q;
        if (!req.run) begin
            ph_d = PH_IDLE;
        end else begin
            unique case (ph_q)
                PH_IDLE:    ph_d = req.want_hi ? PH_HI_WAIT : PH_LO_WAIT;
                PH_HI_WAIT: if (!req.want_hi)   ph_d = PH_LO_WAIT;
                            else if (lo_fb_low) ph_d = PH_HI_DLY;
                PH_HI_DLY:  if (!req.want_hi)   ph_d = PH_LO_WAIT;
                            else if (!lo_fb_low) ph_d = PH_HI_WAIT;
                            else if (timer_done) ph_d = PH_HI_ON;
                PH_HI_ON:   if (!req.want_hi)   ph_d = PH_LO_WAIT;
                PH_LO_WAIT: if (req.want_hi)    ph_d = PH_HI_WAIT;
                            else if (hi_fb_low) ph_d = PH_LO_DLY;
                PH_LO_DLY:  if (req.want_hi)    ph_d = PH_HI_WAIT;
                            else if (!hi_fb_low) ph_d = PH_LO_WAIT;
                            else if (timer_done) ph_d = PH_LO_ON;
                PH_LO_ON:   if (req.want_hi)    ph_d = PH_HI_WAIT;
                default:    ph_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign phase        = ph_q;
    assign timer_active = is_delay(ph_q);
endmodule

// File: rtl/dtg_gate_decode.sv
module dtg_gate_decode
    import dtg_pkg::*;
(
    input  phase_e phase,
    output gate_t  gate
);
    always_comb begin
        gate.hi = (phase == PH_HI_ON);
        gate.lo = (phase == PH_LO_ON);
    end
endmodule

// File: rtl/gate_deadtime_ctrl.sv
module gate_deadtime_ctrl
    import dtg_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int DEAD_TIME_NS  = 40,
    parameter int DEAD_MAX_NS   = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic shutdown,
    input  logic ovp_force,
    input  logic pwm_req,
    input  logic hs_fb_low,
    input  logic ls_fb_low,
    output logic hs_gate_en,
    output logic ls_gate_en
);
    localparam int DLY_CYCLES = calc_dly(DEAD_TIME_NS, DEAD_MAX_NS, CLK_PERIOD_NS);

    req_t   req;
    phase_e phase;
    gate_t  gate;
    logic   tmr_active;
    logic   tmr_done;

    dtg_req_qual u_qual (
        .enable   (enable),
        .shutdown (shutdown),
        .ovp_force(ovp_force),
        .pwm_req  (pwm_req),
        .req      (req)
    );

    dtg_delay_timer #(.DLY(DLY_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .active(tmr_active),
        .done  (tmr_done)
    );

    dtg_phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .hi_fb_low   (hs_fb_low),
        .lo_fb_low   (ls_fb_low),
        .timer_done  (tmr_done),
        .phase       (phase),
        .timer_active(tmr_active)
    );

    dtg_gate_decode u_dec (
        .phase(phase),
        .gate (gate)
    );

    assign hs_gate_en = gate.hi;
    assign ls_gate_en = gate.lo;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
    parameter int DLY = 4
) (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic shutdown,
    input logic ovp_force,
    input logic hs_fb_low,
    input logic ls_fb_low,
    input logic hs_gate_en,
    input logic ls_gate_en
);
    localparam int RW = $clog2(DLY + 2) + 1;
    localparam logic [RW-1:0] CAP = RW'(DLY + 1);

    logic [RW-1:0] ls_run_q;
    logic [RW-1:0] hs_run_q;
    logic          rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            ls_run_q <= '0;
            hs_run_q <= '0;
        end else begin
            ls_run_q <= !ls_fb_low ? '0 : (ls_run_q == CAP ? CAP : ls_run_q + 1'b1);
            hs_run_q <= !hs_fb_low ? '0 : (hs_run_q == CAP ? CAP : hs_run_q + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && rst_d) begin
            AST_RESET_IDLE: assert (!hs_gate_en && !ls_gate_en); // R1
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate_en && ls_gate_en)); // R2

    AST_HS_DEADTIME: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_gate_en) |-> (ls_run_q >= RW'(DLY))); // R3

    AST_LS_DEADTIME: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_gate_en) |-> (hs_run_q >= RW'(DLY))); // R4

    AST_HS_HELD_NO_FB: assert property (@(posedge clk) disable iff (rst)
        (!ls_fb_low && !hs_gate_en) |=> !hs_gate_en); // R6

    AST_LS_HELD_NO_FB: assert property (@(posedge clk) disable iff (rst)
        (!hs_fb_low && !ls_gate_en) |=> !ls_gate_en); // R6

    AST_FORCED_OFF: assert property (@(posedge clk) disable iff (rst)
        (shutdown || !enable) |=> (!hs_gate_en && !ls_gate_en)); // R8

    AST_OVP_HS_OFF: assert property (@(posedge clk) disable iff (rst)
        ovp_force |=> !hs_gate_en); // R9
endmodule

bind gate_deadtime_ctrl dtg_checker #(.DLY(DLY_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .shutdown  (shutdown),
    .ovp_force (ovp_force),
    .hs_fb_low (hs_fb_low),
    .ls_fb_low (ls_fb_low),
    .hs_gate_en(hs_gate_en),
    .ls_gate_en(ls_gate_en)
);

// File: tb/tb_gate_deadtime_ctrl.sv
module tb_gate_deadtime_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_DLY    = 4;   // ceil(40 ns / 10 ns), R11
    localparam int FB_LAT     = 2;   // cycles a gate must be off before its flag reads 1

    logic clk = 1'b0;
    logic rst, enable, shutdown, ovp_force, pwm_req, hs_fb_low, ls_fb_low;
    logic hs_gate_en, ls_gate_en;

    int  n_chk = 0, n_fail = 0;
    int  m_side = 0, m_cnt = -1;   // side: 0 none, 1 high, 2 low; cnt -1 = waiting
    bit  m_on = 0, m_hs = 0, m_ls = 0;
    int  hs_age = 100, ls_age = 100;
    bit  hold_hs = 0, hold_ls = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_deadtime_ctrl dut (
        .clk(clk), .rst(rst), .enable(enable), .shutdown(shutdown),
        .ovp_force(ovp_force), .pwm_req(pwm_req),
        .hs_fb_low(hs_fb_low), .ls_fb_low(ls_fb_low),
        .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en)
    );

    task automatic chk_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit fb;
        int want;
        if (rst || !enable || shutdown) begin
            m_side = 0; m_on = 0; m_cnt = -1;
        end else begin
            want = (pwm_req && !ovp_force) ? 1 : 2;
            if (m_side != want) begin
                m_side = want; m_on = 0; m_cnt = -1;
            end else if (!m_on) begin
                fb = (m_side == 1) ? ls_fb_low : hs_fb_low;
                if (!fb)                     m_cnt = -1;
                else if (m_cnt < 0)          m_cnt = 0;
                else if (m_cnt == EXP_DLY-1) m_on = 1;
                else                         m_cnt++;
            end
        end
        m_hs = (m_side == 1) && m_on;
        m_ls = (m_side == 2) && m_on;
        hs_age = m_hs ? 0 : (hs_age < 1000 ? hs_age + 1 : hs_age);
        ls_age = m_ls ? 0 : (ls_age < 1000 ? ls_age + 1 : ls_age);
    endtask

    // One clock: drive feedback, advance the model, sample after the edge
    task automatic tick(input string tag);
        hs_fb_low = (hs_age >= FB_LAT) && !hold_hs;
        ls_fb_low = (ls_age >= FB_LAT) && !hold_ls;
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk_int({tag, " hs_gate_en"}, int'(hs_gate_en), int'(m_hs));
        chk_int({tag, " ls_gate_en"}, int'(ls_gate_en), int'(m_ls));
        chk_int("R2 overlap", int'(hs_gate_en && ls_gate_en), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        int lat;
        rst = 1; enable = 0; shutdown = 0; ovp_force = 0; pwm_req = 0;
        hs_fb_low = 1; ls_fb_low = 1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick("R1 reset");
        rst = 0;
        chk_int("R1 reset hs", int'(hs_gate_en), 0);
        chk_int("R1 reset ls", int'(ls_gate_en), 0);
        for (int i = 0; i < 6; i++) begin pwm_req = i[0]; tick("R1 disabled"); end

        // R4 / R11: first start to the low side
        enable = 1; pwm_req = 0; lat = 0;
        for (int i = 1; i <= 40; i++) begin tick("R4"); if (ls_gate_en) begin lat = i; break; end end
        chk_int("R4 R11 low-side latency", lat, 2 + EXP_DLY);

        // R10: held low request
        cnt = 0;
        for (int i = 0; i < 25; i++) begin tick("R10"); if (!ls_gate_en) cnt++; end
        chk_int("R10 low-side drops", cnt, 0);

        // R3 / R11: side change to high
        pwm_req = 1; lat = 0;
        for (int i = 1; i <= 40; i++) begin
            tick("R3");
            if (i == 1) chk_int("R11 ls off at first edge", int'(ls_gate_en), 0);
            if (hs_gate_en) begin lat = i; break; end
        end
        chk_int("R3 high-side latency", lat, FB_LAT + 1 + EXP_DLY);

        cnt = 0;
        for (int i = 0; i < 25; i++) begin tick("R10"); if (!hs_gate_en) cnt++; end
        chk_int("R10 high-side drops", cnt, 0);

        // R6: high-side flag withheld, low side must wait forever
        pwm_req = 0; hold_hs = 1; cnt = 0;
        for (int i = 0; i < 40; i++) begin tick("R6"); if (ls_gate_en) cnt++; end
        chk_int("R6 ls lit without feedback", cnt, 0);
        hold_hs = 0; lat = 0;
        for (int i = 1; i <= 20; i++) begin tick("R6 release"); if (ls_gate_en) begin lat = i; break; end end
        chk_int("R6 ls after release", lat, 1 + EXP_DLY);

        // R5: feedback glitch during the delay restarts it
        pwm_req = 1; lat = 0;
        for (int i = 1; i <= 40; i++) begin
            hold_ls = (i == FB_LAT + 2);
            tick("R5");
            if (hs_gate_en) begin lat = i; break; end
        end
        hold_ls = 0;
        chk_int("R5 restarted latency", lat, FB_LAT + 3 + EXP_DLY);

        // R7: request reversed while the low side is in its delay
        lat = 0; cnt = 0;
        for (int i = 1; i <= 40; i++) begin
            pwm_req = (i >= 4);
            tick("R7");
            if (ls_gate_en) cnt++;
            if (hs_gate_en && i > 1) begin lat = i; break; end
        end
        chk_int("R7 superseded ls lit", cnt, 0);
        chk_int("R7 high-side relatency", lat, 5 + EXP_DLY);

        // R8: shutdown and enable drop
        shutdown = 1; tick("R8 shutdown");
        chk_int("R8 shutdown hs", int'(hs_gate_en), 0);
        for (int i = 0; i < 5; i++) tick("R8 held");
        shutdown = 0; lat = 0;
        for (int i = 1; i <= 40; i++) begin tick("R8 release"); if (hs_gate_en) begin lat = i; break; end end
        chk_int("R8 restart latency", lat, 2 + EXP_DLY);
        enable = 0; tick("R8 disable");
        chk_int("R8 disable hs", int'(hs_gate_en), 0);
        enable = 1;
        for (int i = 0; i < 12; i++) tick("R8 re-enable");
        chk_int("R8 re-enable hs", int'(hs_gate_en), 1);

        // R9: over-voltage override with high request
        ovp_force = 1; tick("R9");
        chk_int("R9 hs off next edge", int'(hs_gate_en), 0);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin tick("R9 held"); if (hs_gate_en) cnt++; end
        chk_int("R9 hs lit under override", cnt, 0);
        chk_int("R9 ls held on", int'(ls_gate_en), 1);
        ovp_force = 0;
        for (int i = 0; i < 12; i++) tick("R9 release");
        chk_int("R9 hs after release", int'(hs_gate_en), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule